// File: doc/BRIEF.md
# Package Forced-Idle Residency Counters

This block measures how long a processor package stays in a low-power state while hardware duty cycling holds at least one core idle. It keeps two 64-bit counters that software can only read. The shallow counter measures residency in package C2. The deep counter measures residency in a package state range that software picks through a 3-bit select held in a configuration register. A count is added only on a timestamp tick, and only while the package is in the monitored state and the forced-idle flag is high.

Ticks are not added to the visible counter one at a time. During a residency episode they build up in a private pending total. When the package leaves the monitored state, the whole total is added to the counter in one step. If software changes the deep select while an episode is running, that episode is spoiled and adds nothing.

Software reaches the counters and the select through a single-cycle request port. A response comes back exactly one cycle after each request. When the feature-present strap is low, every access returns an error.

Top module: `pkg_idle_residency`

## Requirements
- R1: After reset, both counters and the deep select read as zero. A zero select means the deep counter does not count.
- R2: Package state codes are 0=C0, 1=C2, 2=C3, 3=C6, 4=C7. A tick qualifies when `ts_tick` and `core_forced_idle` are both high while the package is in the monitored state. The shallow counter monitors code 1 only.
- R3: A counter keeps its value during an episode. In the cycle after the package state leaves the monitored set, the counter grows by the number of qualifying ticks in that episode, in a single step.
- R4: A tick does not count when `core_forced_idle` is low or when the package is outside the monitored state.
- R5: The deep select works as follows. 0 counts nothing. 1 counts state code 1 only. 2, 3 and 4 count every state code greater than or equal to the select value, which means C3 and deeper, C6 and deeper, and C7 and deeper.
- R6: Address 2 holds the select in bits 2:0, and the other bits read as zero. A write with a value above 4, or with any of bits 63:3 set, returns an error and leaves the select unchanged.
- R7: Address 0 is the shallow counter and address 1 is the deep counter. A write to either one returns an error and leaves the counter unchanged.
- R8: If a write changes the select value while a deep episode is running, the deep counter gets nothing from that episode.
- R9: While `feat_present` is low, every access returns an error with data zero and changes no state.
- R10: `rsp_valid` goes high exactly one cycle after each request. A request to address 3 returns an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_tick | input | 1 | Timestamp tick strobe |
| pkg_state | input | 3 | Package state code (R2) |
| core_forced_idle | input | 1 | At least one core is held idle by duty cycling |
| feat_present | input | 1 | Feature-present strap |
| reg_req | input | 1 | Access request |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Access error |
| rsp_rdata | output | 64 | Read data |

## Verification
The main function is driven with several kinds of episode:
- Continuous ticks and every-other-cycle ticks, which show that ticks are counted rather than cycles.
- Episodes with forced idle low or with the package outside the monitored state, which show that each qualifier gates on its own.
- Episodes at each state depth under each deep select value, which separate the exact-match C2 rule from the greater-or-equal rule and show how the shallow and deep counters overlap.
- Counter reads in the middle of an episode, which show that nothing is committed before exit.
- A select change in the middle of an episode, followed by a clean episode, which shows that only the spoiled episode is dropped.

A behavioural model is compared against every response on every clock.

// File: rtl/idle_res_pkg.sv
package idle_res_pkg;
  localparam int REG_W   = 64;
  localparam int SEL_W   = 3;
  localparam int STATE_W = 3;
  localparam int ADDR_W  = 2;
  localparam logic [SEL_W-1:0] SEL_MAX = 3'd4;

  typedef enum logic [STATE_W-1:0] {
    PS_C0 = 3'd0, PS_C2 = 3'd1, PS_C3 = 3'd2, PS_C6 = 3'd3, PS_C7 = 3'd4
  } pkg_state_e;

  typedef enum logic [ADDR_W-1:0] {
    RA_SHALLOW = 2'd0, RA_DEEP = 2'd1, RA_SEL = 2'd2, RA_NONE = 2'd3
  } reg_addr_e;

  // Select 1 matches C2 exactly; selects 2..4 match the state at that depth or deeper.
  function automatic logic deep_match(input logic [SEL_W-1:0] sel,
                                      input logic [STATE_W-1:0] st);
    logic hit;
    case (sel)
      3'd0:                hit = 1'b0;
      3'd1:                hit = (st == PS_C2);
      3'd2, 3'd3, 3'd4:    hit = (st >= STATE_W'(sel));
      default:             hit = 1'b0;
    endcase
    return hit;
  endfunction

  // A select write is legal when reserved bits are clear and the code is defined.
  function automatic logic sel_write_ok(input logic [REG_W-1:0] wd);
    return (wd[REG_W-1:SEL_W] == '0) && (wd[SEL_W-1:0] <= SEL_MAX);
  endfunction
endpackage

// File: rtl/res_tracker.sv
module res_tracker #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_now,
  input  logic             qual,
  input  logic             discard,
  output logic [CNT_W-1:0] cnt
);
  logic             prev_q, poison_q;
  logic [CNT_W-1:0] pend_q, cnt_q;

  logic exit_ev, commit_ev, step_ev;
  assign exit_ev   = prev_q & ~in_now;
  assign commit_ev = exit_ev & ~discard;
  assign step_ev   = in_now & qual & ~poison_q & ~discard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      poison_q <= 1'b0;
      pend_q   <= '0;
      cnt_q    <= '0;
    end else begin
      prev_q <= in_now;
      if (commit_ev) cnt_q <= cnt_q + pend_q;
      if (discard || exit_ev) pend_q <= '0;
      else if (step_ev)       pend_q <= pend_q + 1'b1;
      if (discard)      poison_q <= in_now;
      else if (exit_ev) poison_q <= 1'b0;
    end
  end

  assign cnt = cnt_q;

  // R3: visible count moves only on a commit, and then by the pending total
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(cnt_q));
  a_r3_commit_sum: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> cnt_q == $past(cnt_q) + $past(pend_q));
  // R4: nothing gathers outside the monitored state
  a_r4_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !in_now |=> pend_q == '0);
  // R8: a spoiled episode holds an empty pending total
  a_r8_poison_empty: assert property (@(posedge clk) disable iff (!rst_n)
    poison_q |-> pend_q == '0);
endmodule

// File: rtl/res_regif.sv
module res_regif
  import idle_res_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_present,
  input  logic             reg_req,
  input  logic             reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0] cnt_shallow,
  input  logic [CNT_W-1:0] cnt_deep,
  output logic [SEL_W-1:0] sel,
  output logic             sel_change,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [REG_W-1:0] rsp_rdata
);
  logic [SEL_W-1:0] sel_q;
  logic             acc_ok, bad_acc, sel_wr;
  logic [REG_W-1:0] rd_val;

  assign acc_ok = reg_req & feat_present;

  always_comb begin
    bad_acc = 1'b0;
    rd_val  = '0;
    sel_wr  = 1'b0;
    case (reg_addr)
      RA_SHALLOW: begin bad_acc = reg_we; rd_val = REG_W'(cnt_shallow); end
      RA_DEEP:    begin bad_acc = reg_we; rd_val = REG_W'(cnt_deep); end
      RA_SEL: begin
        rd_val = REG_W'(sel_q);
        if (reg_we) begin
          bad_acc = ~sel_write_ok(reg_wdata);
          sel_wr  = sel_write_ok(reg_wdata);
        end
      end
      default: bad_acc = 1'b1;
    endcase
  end

  assign sel_change = acc_ok & sel_wr & (reg_wdata[SEL_W-1:0] != sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (acc_ok && sel_wr) sel_q <= reg_wdata[SEL_W-1:0];
      rsp_valid <= reg_req;
      rsp_err   <= reg_req & (~feat_present | bad_acc);
      rsp_rdata <= (acc_ok && !reg_we && !bad_acc) ? rd_val : '0;
    end
  end

  assign sel = sel_q;

  // R6: the select never holds a reserved code
  a_r6_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= SEL_MAX);
  // R9: an access without the feature faults with zero data and no state change
  a_r9_fault: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !feat_present |=> rsp_err && rsp_rdata == '0 && $stable(sel_q));
  // R10: one response per request, one cycle later
  a_r10_rsp_one: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> rsp_valid);
  a_r10_rsp_none: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_req |=> !rsp_valid);
endmodule

// File: rtl/pkg_idle_residency.sv
module pkg_idle_residency
  import idle_res_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ts_tick,
  input  logic [STATE_W-1:0] pkg_state,
  input  logic               core_forced_idle,
  input  logic               feat_present,
  input  logic               reg_req,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [REG_W-1:0]   rsp_rdata
);
  localparam int NCNT = 2;   // index 0 shallow, 1 deep

  logic [SEL_W-1:0] sel;
  logic             sel_change;
  logic             qual;
  logic [NCNT-1:0]  in_mon, disc;
  logic [CNT_W-1:0] cnt [NCNT];

  assign qual      = ts_tick & core_forced_idle;
  assign in_mon[0] = (pkg_state == PS_C2);
  assign in_mon[1] = deep_match(sel, pkg_state);
  assign disc      = {sel_change, 1'b0};

  for (genvar i = 0; i < NCNT; i++) begin : g_trk
    res_tracker #(.CNT_W(CNT_W)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_now  (in_mon[i]),
      .qual    (qual),
      .discard (disc[i]),
      .cnt     (cnt[i])
    );
  end

  res_regif #(.CNT_W(CNT_W)) u_regif (
    .clk          (clk),
    .rst_n        (rst_n),
    .feat_present (feat_present),
    .reg_req      (reg_req),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .cnt_shallow  (cnt[0]),
    .cnt_deep     (cnt[1]),
    .sel          (sel),
    .sel_change   (sel_change),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata)
  );

  // R5: with select zero the deep tracker never sees its state
  a_r5_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel == '0 |-> !in_mon[1]);
endmodule

// File: tb/pkg_idle_residency_bench.sv
module pkg_idle_residency_bench;
  localparam time CLK_PER = 10ns;
  localparam int  WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts_tick = 1'b0;
  logic [2:0]  pkg_state = '0;
  logic        core_forced_idle = 1'b0;
  logic        feat_present = 1'b1;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  always #(CLK_PER/2) clk = ~clk;

  pkg_idle_residency u_pkg_idle_residency (
    .clk(clk), .rst_n(rst_n), .ts_tick(ts_tick), .pkg_state(pkg_state),
    .core_forced_idle(core_forced_idle), .feat_present(feat_present),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1";

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  longint unsigned m_cnt[2], m_pend[2];
  bit    m_prev[2], m_poison[2];
  int    m_sel;
  bit    e_vld, e_err;
  longint unsigned e_dat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '{0, 0}; m_pend = '{0, 0}; m_prev = '{0, 0}; m_poison = '{0, 0};
      m_sel = 0; e_vld = 0; e_err = 0; e_dat = 0;
    end else begin
      bit wr_ok, spoil;
      bit in_m[2];
      wr_ok = 0;
      e_vld = reg_req; e_err = 0; e_dat = 0;
      if (reg_req) begin
        if (!feat_present) e_err = 1;
        else if (reg_addr == 0 || reg_addr == 1) begin
          if (reg_we) e_err = 1; else e_dat = m_cnt[reg_addr];
        end else if (reg_addr == 2) begin
          if (!reg_we) e_dat = m_sel;
          else if (reg_wdata > 64'd4) e_err = 1;
          else wr_ok = 1;
        end else e_err = 1;
      end
      in_m[0] = (pkg_state == 1);
      if (m_sel == 0) in_m[1] = 0;
      else if (m_sel == 1) in_m[1] = (pkg_state == 1);
      else in_m[1] = (int'(pkg_state) >= m_sel);
      spoil = wr_ok && (int'(reg_wdata) != m_sel);
      for (int i = 0; i < 2; i++) begin
        bit d, ex;
        d  = (i == 1) && spoil;
        ex = m_prev[i] && !in_m[i];
        if (ex && !d) m_cnt[i] += m_pend[i];
        if (d || ex) m_pend[i] = 0;
        else if (in_m[i] && ts_tick && core_forced_idle && !m_poison[i]) m_pend[i]++;
        if (d) m_poison[i] = in_m[i];
        else if (ex) m_poison[i] = 0;
        m_prev[i] = in_m[i];
      end
      if (wr_ok) m_sel = int'(reg_wdata);
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_tag, " vld"}, 64'(rsp_valid), 64'(e_vld));
      if (e_vld) begin
        chk({cur_tag, " err"}, 64'(rsp_err), 64'(e_err));
        chk({cur_tag, " data"}, rsp_rdata, e_dat);
      end
    end
  end

  // Directed access: drive at a falling edge, check the response one cycle later
  task automatic acc(input bit we, input logic [1:0] a, input logic [63:0] wd,
                     input bit exp_err, input logic [63:0] exp_dat, input string tag);
    @(negedge clk);
    reg_req = 1; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    chk({tag, " rsp_err"}, 64'(rsp_err), 64'(exp_err));
    if (!we) chk({tag, " rsp_rdata"}, rsp_rdata, exp_dat);
  endtask

  task automatic episode(input logic [2:0] st, input int n, input bit forced, input bit every_other);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pkg_state = st; core_forced_idle = forced;
      ts_tick = every_other ? (k % 2 == 0) : 1'b1;
    end
    @(negedge clk);
    pkg_state = 0; ts_tick = 0; core_forced_idle = 0;
    repeat (2) @(negedge clk);
  endtask

  longint unsigned sh, dp;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    sh = 0; dp = 0;

    cur_tag = "R1";
    acc(0, 0, 0, 0, 0, "R1 shallow reset");
    acc(0, 1, 0, 0, 0, "R1 deep reset");
    acc(0, 2, 0, 0, 0, "R1 select reset");

    // R2/R3: ten cycles in C2, tick every other cycle -> 5 counts
    cur_tag = "R2";
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      pkg_state = 1; core_forced_idle = 1; ts_tick = (k % 2 == 0);
    end
    cur_tag = "R3";
    acc(0, 0, 0, 0, 0, "R3 mid-episode shallow unchanged");
    @(negedge clk);
    pkg_state = 0; ts_tick = 0; core_forced_idle = 0;
    @(negedge clk);
    sh = 5;
    acc(0, 0, 0, 0, sh, "R2 shallow after exit");
    acc(0, 1, 0, 0, dp, "R1 deep idle with select zero");

    // R4: forced-idle low, or outside the state
    cur_tag = "R4";
    episode(1, 6, 0, 0);
    episode(2, 4, 1, 0);
    acc(0, 0, 0, 0, sh, "R4 shallow unchanged");

    // R5: select encodings
    cur_tag = "R5";
    acc(1, 2, 64'd2, 0, 0, "R5 write select 2");
    episode(3, 4, 1, 0); dp += 4;
    acc(0, 1, 0, 0, dp, "R5 select 2 counts C6");
    acc(0, 0, 0, 0, sh, "R5 shallow ignores C6");
    acc(1, 2, 64'd1, 0, 0, "R5 write select 1");
    episode(1, 3, 1, 0); dp += 3; sh += 3;
    episode(2, 3, 1, 0);
    acc(0, 1, 0, 0, dp, "R5 select 1 counts C2 only");
    acc(0, 0, 0, 0, sh, "R5 shallow C2");
    acc(1, 2, 64'd4, 0, 0, "R5 write select 4");
    episode(3, 3, 1, 0);
    episode(4, 2, 1, 0); dp += 2;
    acc(0, 1, 0, 0, dp, "R5 select 4 counts C7 only");

    // R6: illegal select writes
    cur_tag = "R6";
    acc(1, 2, 64'd5, 1, 0, "R6 reserved code");
    acc(1, 2, 64'h9, 1, 0, "R6 reserved bits");
    acc(0, 2, 0, 0, 64'd4, "R6 select kept");

    // R7: counters are read-only
    cur_tag = "R7";
    acc(1, 0, 64'd77, 1, 0, "R7 write shallow");
    acc(1, 1, 64'd77, 1, 0, "R7 write deep");
    acc(0, 0, 0, 0, sh, "R7 shallow kept");
    acc(0, 1, 0, 0, dp, "R7 deep kept");

    // R8: select change mid-episode spoils it
    cur_tag = "R8";
    acc(1, 2, 64'd2, 0, 0, "R8 write select 2");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); pkg_state = 3; core_forced_idle = 1; ts_tick = 1;
    end
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 2; reg_wdata = 64'd3;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    chk("R8 mid-episode write accepted", 64'(rsp_err), 64'd0);
    repeat (2) @(negedge clk);
    pkg_state = 0; ts_tick = 0; core_forced_idle = 0;
    repeat (2) @(negedge clk);
    acc(0, 1, 0, 0, dp, "R8 spoiled episode adds nothing");
    episode(3, 2, 1, 0); dp += 2;
    acc(0, 1, 0, 0, dp, "R8 next episode counts");

    // R9: feature absent
    cur_tag = "R9";
    @(negedge clk); feat_present = 0;
    acc(0, 0, 0, 1, 0, "R9 read faults");
    acc(1, 2, 64'd1, 1, 0, "R9 write faults");
    @(negedge clk); feat_present = 1;
    acc(0, 2, 0, 0, 64'd3, "R9 select unchanged");

    // R10: unmapped address
    cur_tag = "R10";
    acc(0, 3, 0, 1, 0, "R10 unmapped read");
    acc(1, 3, 64'd1, 1, 0, "R10 unmapped write");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule